// File: doc/BRIEF.md
# Burst-Mode Manchester Receiver with Clock Rebuild

This block turns a bi-phase-level serial line back into data and a bit clock. It needs no phase-locked loop. A sample clock runs at `SPB` times the nominal baud rate, and `SPB` is a parameter. The line is brought into that domain through two flops. The block then counts sample intervals from the last edge it accepted as a mid-cell edge. An edge that arrives before three quarters of a nominal bit has passed is a cell-boundary edge, and the block does not use it for data. The first edge after reset or after a quiet gap is taken as a mid-cell edge, so decoding starts within the first bit cell of a burst and needs no preamble.

The data output carries the inverse of each decoded bit. The clock output is the synchronised line, delayed. When a bit differs from the bit before it, or is the first bit of a burst, the clock output is held low for half a nominal bit, counted from that bit's mid-cell edge. Its falling edges therefore always come from the line, and they keep the sender's timing. Its rising edges never meet a change of the data output.

A burst must begin with the line already at the level of the first half-cell of its first bit. In practice the line stays where the previous burst left it, and the sender picks a first bit to match. `SPB` must be a multiple of 4 and at least 8.

Top module: `manch_dec`

## Requirements
- R1: A mid-cell fall of the line decodes as bit 1, and a mid-cell rise decodes as bit 0.
- R2: `dat_n_out` carries the inverse of the decoded bit: 0 after a 1 and 1 after a 0. It changes 3 sample-clock cycles after the line changes, and then holds until the next accepted edge.
- R3: An edge that comes fewer than 3*SPB/4 samples after the last accepted edge leaves `dat_n_out` and `dat_valid` unchanged.
- R4: After reset or an idle period, the first edge is accepted as a mid-cell edge. `dat_valid` rises in the same cycle as the first decoded value, and it is low in the cycle before.
- R5: Decoding stays correct for bit periods from 14 to 18 samples at SPB = 16, which is about ±12% around nominal.
- R6: When a bit differs from the previous bit, or is the first bit after idle, `bclk_out` is low for the SPB/2 cycles that start with the cycle in which `dat_n_out` takes the new value.
- R7: In every other case, `bclk_out` equals the line level from 3 sample-clock cycles earlier.
- R8: `bclk_out` falls only in a cycle in which the delayed line level also falls.
- R9: `dat_n_out` does not change in any cycle in which `bclk_out` rises.
- R10: If 3*SPB/2 samples pass with no accepted edge, `dat_valid` falls on the following cycle and `dat_n_out` keeps its value. The block then waits for a new first edge.
- R11: While `rst_n` is low, the block is held in reset at each clock edge whatever the line does: `bclk_out`, `dat_n_out` and `dat_valid` stay low, and the block is left idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, SPB times the nominal baud rate |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Asynchronous Manchester line |
| bclk_out | output | 1 | Rebuilt bit clock |
| dat_n_out | output | 1 | Inverted decoded data, valid at the rising edges of `bclk_out` |
| dat_valid | output | 1 | High while the decoder holds a bit from the current burst |

## Verification
The bound checker watches four things on every cycle. Data is stable at each rising edge of the rebuilt clock. Every clock fall coincides with a fall of the delayed line. A change of the data output, or a rise of the valid flag, happens only while the clock is low. The valid flag is low after a long quiet line. Other behaviour can only be shown by the scoreboard scenarios, which compare expected values against the outputs at fixed cycle offsets. These are the decoded values for each bit, the rejection of cell-boundary edges, the exact length of the forced-low window, and tolerance of fast and slow bit periods. They also cover the idle timeout, including the exact cycle in which valid drops, and re-acquisition of a second and a third burst from the level each burst leaves behind.

// File: rtl/manch_dec.sv
module manch_dec #(
  parameter int SPB = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic bclk_out,
  output logic dat_n_out,
  output logic dat_valid
);
  localparam int WIN      = (3 * SPB) / 4;
  localparam int IDLE_LIM = (3 * SPB) / 2;
  localparam int HALF     = SPB / 2;
  localparam int CW       = $clog2(IDLE_LIM + 1);
  localparam int FW       = $clog2(HALF + 1);

  logic          sy1, sy2, dly;
  logic [CW-1:0] gap;
  logic [FW-1:0] hold;
  logic          idle, last_bit, dat_q, vld_q;

  wire edge_seen = sy2 ^ dly;
  wire open_win  = idle | (gap >= CW'(WIN));
  wire take      = edge_seen & open_win;
  wire new_bit   = ~sy2;
  wire differ    = idle | (new_bit != last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1      <= 1'b0;
      sy2      <= 1'b0;
      dly      <= 1'b0;
      gap      <= '0;
      hold     <= '0;
      idle     <= 1'b1;
      last_bit <= 1'b0;
      dat_q    <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      sy1 <= rx_in;
      sy2 <= sy1;
      dly <= sy2;
      if (take) begin
        gap      <= '0;
        idle     <= 1'b0;
        last_bit <= new_bit;
        dat_q    <= sy2;
        vld_q    <= 1'b1;
        hold     <= differ ? FW'(HALF) : '0;
      end else begin
        if (gap != CW'(IDLE_LIM)) gap <= gap + 1'b1;
        if (!idle && gap == CW'(IDLE_LIM)) begin
          idle  <= 1'b1;
          vld_q <= 1'b0;
        end
        if (hold != '0) hold <= hold - 1'b1;
      end
    end
  end

  assign bclk_out  = dly & (hold == '0);
  assign dat_n_out = dat_q;
  assign dat_valid = vld_q;
endmodule

// File: rtl/manch_dec_chk.sv
module manch_dec_chk #(
  parameter int SPB = 16
) (
  input logic clk,
  input logic rst_n,
  input logic bclk_out,
  input logic dat_n_out,
  input logic dat_valid,
  input logic line_d
);
  localparam int IDLE_LIM = (3 * SPB) / 2;

  int   quiet;
  logic line_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet  <= 0;
      line_p <= 1'b0;
    end else begin
      line_p <= line_d;
      if (line_d != line_p) quiet <= 0;
      else if (quiet < IDLE_LIM + 4) quiet <= quiet + 1;
    end
  end

  assert_dat_stable_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_out) |-> $stable(dat_n_out));

  assert_fall_follows_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_out) |-> $fell(line_d));

  assert_change_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_n_out) |-> !bclk_out);

  assert_valid_rise_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_valid) |-> !bclk_out);

  assert_idle_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= IDLE_LIM + 2 && line_d == line_p) |-> !dat_valid);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!bclk_out && !dat_n_out && !dat_valid));
endmodule

bind manch_dec manch_dec_chk #(.SPB(SPB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_out(bclk_out),
  .dat_n_out(dat_n_out), .dat_valid(dat_valid), .line_d(dly)
);

// File: tb/manch_dec_bench.sv
module manch_dec_bench;
  localparam int SPB  = 16;
  localparam int HALF = SPB / 2;
  localparam int IDLE = (3 * SPB) / 2;

  typedef struct {
    int    due;
    logic  dn;
    logic  ck;
    bit    ckc;
    logic  v;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic bclk, dn, vld;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  logic last_dn = 1'b0;
  item_t sbq[$];

  always #10 clk = ~clk;

  manch_dec #(.SPB(SPB)) u_manch_dec (
    .clk(clk), .rst_n(rst_n), .rx_in(rx),
    .bclk_out(bclk), .dat_n_out(dn), .dat_valid(vld)
  );

  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0] hist = '0;
  logic pck = 1'b0, pdn = 1'b0;

  always @(posedge clk) begin
    #1;
    hist = {hist[2:0], rx};
    if (rst_n) begin
      if (!pck && bclk) begin
        checks++;
        if (dn !== pdn) begin
          fails++;
          $display("FAIL R9 data moved at clock rise: actual %b expected %b", dn, pdn);
        end
      end
      if (pck && !bclk) begin
        checks++;
        if (!(hist[2] == 1'b0 && hist[3] == 1'b1)) begin
          fails++;
          $display("FAIL R8 clock fell without line fall: actual %b%b expected 10", hist[3], hist[2]);
        end
      end
    end
    pck = bclk;
    pdn = dn;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (it.due != cyc || dn !== it.dn || (it.ckc && bclk !== it.ck) || vld !== it.v) begin
        fails++;
        $display("FAIL %s at cycle %0d: actual dn=%b ck=%b v=%b expected dn=%b ck=%b v=%b",
                 it.req, cyc, dn, bclk, vld, it.dn, it.ck, it.v);
      end
    end
  end

  task automatic push(input int due, input logic d, input logic c, input bit cc,
                      input logic v, input string req);
    item_t it;
    it.due = due; it.dn = d; it.ck = c; it.ckc = cc; it.v = v; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic send_burst(input logic [15:0] bits, input int len, input int per,
                            input string tol);
    logic prev = 1'b0;
    bit   fprev = 0;
    int   due = 0;
    for (int i = 0; i < len; i++) begin
      logic b;
      bit   forced;
      b = bits[len-1-i];
      if (i > 0 && rx != b) begin
        rx = b;
        push(cyc + 3, ~prev, b, !(fprev && per / 2 < HALF), 1'b1, {"R3 R7 ", tol});
      end
      repeat (per / 2) @(negedge clk);
      rx = ~b;
      due = cyc + 3;
      forced = (i == 0) || (b != prev);
      if (i == 0) push(due - 1, last_dn, 1'b0, 0, 1'b0, "R4 before first");
      push(due, ~b, forced ? 1'b0 : ~b, 1, 1'b1,
           {forced ? "R1 R2 R6 " : "R1 R2 R7 ", (i == 0) ? "R4 " : "", tol});
      if (forced) push(due + HALF - 1, ~b, 1'b0, 1, 1'b1, {"R6 hold end ", tol});
      prev = b;
      fprev = forced;
      repeat (per - per / 2) @(negedge clk);
    end
    last_dn = ~prev;
    push(due + IDLE, last_dn, 1'b0, 0, 1'b1, "R10 still valid");
    push(due + IDLE + 1, last_dn, 1'b0, 0, 1'b0, "R10 dropped, data kept");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (bclk !== 1'b0 || dn !== 1'b0 || vld !== 1'b0) begin
      fails++;
      $display("FAIL R11 in reset: actual %b%b%b expected 000", bclk, dn, vld);
    end
    rx = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (bclk !== 1'b0 || dn !== 1'b0 || vld !== 1'b0) begin
      fails++;
      $display("FAIL R11 after release: actual %b%b%b expected 000", bclk, dn, vld);
    end
    send_burst(16'b001101001, 9, 16, "nominal");
    repeat (40) @(negedge clk);
    send_burst(16'b01110010, 8, 14, "R5 fast");
    repeat (40) @(negedge clk);
    send_burst(16'b1001101, 7, 18, "R5 slow");
    repeat (40) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule